// File: doc/BRIEF.md
# Power-Down and Initialization Sequencer

This block sits between a converter's decimation output and its serial port. It follows an active-low power-down input. While that input is low, the block holds the downstream filter in reset, forces both sample outputs to zero and keeps the valid flag low. After release it measures an initialization window in frame periods. A frame period is one period of the left/right frame clock. During that window both channels are held at two's-complement zero. When the window ends, the live sample pair passes through.

The window length depends on the clocking role. When the block produces the frame clock (master), counting starts as soon as power-down is released. When the frame clock comes from outside (slave), the block stays idle until the first frame edge arrives, and only then starts counting. The format input selects which LRCK transition marks a frame: the rising edge for the MSB-justified layout, the falling edge for the I2S layout. All logic runs on the system (master) clock. The frame clock is treated as a level that is synchronous to that clock.

Top module: `pd_init_seq`

## Requirements
- R1: `filt_rst_o` is 1 whenever `pdn_n` is 0, and it rises at once (asynchronously) when `pdn_n` falls.
- R2: After `pdn_n` rises, `filt_rst_o` stays 1 until the first rising edge of `clk` and is 0 after that edge.
- R3: While `pdn_n` is 0, `smp_valid_o` is 0 and both sample outputs are 0, whatever the sample inputs carry.
- R4: During initialization, `smp_valid_o` is 0 and both sample outputs are 0 even when the sample inputs are non-zero.
- R5: With `master_mode`=1, counting starts at release. `smp_valid_o` rises on the second rising `clk` edge after the LRCK transition that forms the 4129th frame edge after release, and it is 0 before that.
- R6: With `master_mode`=0, the first frame edge after release starts the count. `smp_valid_o` rises on the second rising `clk` edge after the 4132nd frame edge that follows the starting edge.
- R7: A frame edge is an LRCK rise when `i2s_fmt`=0 and an LRCK fall when `i2s_fmt`=1. In slave mode, a frame clock held constant keeps the block in its idle, invalid state indefinitely.
- R8: Once valid, `smp_l_o`/`smp_r_o` equal `smp_l_i`/`smp_r_i` as sampled on the previous rising `clk` edge, and `smp_valid_o` stays 1 while `pdn_n` is 1.
- R9: Pulling `pdn_n` low during initialization or during normal operation aborts at once. The next release restarts the full window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System (master) clock |
| pdn_n | input | 1 | Power-down, active low; also the block's reset |
| master_mode | input | 1 | 1: frame clock produced locally; 0: frame clock supplied externally |
| i2s_fmt | input | 1 | 1: I2S layout (falling frame edge); 0: MSB-justified (rising frame edge) |
| lrck | input | 1 | Frame clock level, synchronous to `clk` |
| smp_l_i | input | W | Left sample from the filter |
| smp_r_i | input | W | Right sample from the filter |
| smp_l_o | output | W | Gated left sample |
| smp_r_o | output | W | Gated right sample |
| smp_valid_o | output | 1 | Sample pair carries live data |
| filt_rst_o | output | 1 | Reset for the downstream filter state |

## Verification
Several properties hold on every cycle while power-down is released. Outputs are zero whenever the valid flag is low. The filter reset lasts one cycle after release. The frame counter never reaches the window length. The armed (waiting) state occurs only in slave mode. Normal operation is entered only from initialization, and the valid flag never drops while power-down stays high. Other behaviour only the directed scenarios can show: the exact frame edge on which valid rises in each mode and format, the choice of edge polarity, waiting for an absent frame clock, and the asynchronous response to power-down together with the full restart after an abort.

// File: rtl/pdseq_pkg.sv
package pdseq_pkg;
   typedef enum logic [1:0] {
      PD_OFF  = 2'd0,
      PD_ARM  = 2'd1,
      PD_INIT = 2'd2,
      PD_RUN  = 2'd3
   } pd_state_e;
endpackage

// File: rtl/pdseq_frame_edge.sv
module pdseq_frame_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic lrck,
   input  logic fall_sel,
   output logic edge_o
);
   logic lrck_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lrck_q <= 1'b0;
      else        lrck_q <= lrck;
   end

   // rising edge for MSB-justified, falling edge for I2S
   assign edge_o = fall_sel ? (lrck_q & ~lrck) : (~lrck_q & lrck);
endmodule

// File: rtl/pdseq_ctrl.sv
module pdseq_ctrl
   import pdseq_pkg::*;
#(
   parameter int MASTER_FRAMES = 4129,
   parameter int SLAVE_FRAMES  = 4132
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      is_master,
   input  logic      frame_edge,
   output pd_state_e state_o
);
   localparam int LONGEST = (MASTER_FRAMES > SLAVE_FRAMES) ? MASTER_FRAMES : SLAVE_FRAMES;
   localparam int CW      = $clog2(LONGEST + 1);

   if (MASTER_FRAMES < 1) begin : g_bad_master
      $error("MASTER_FRAMES must be at least 1");
   end
   if (SLAVE_FRAMES < 1) begin : g_bad_slave
      $error("SLAVE_FRAMES must be at least 1");
   end

   pd_state_e         state_q;
   logic [CW-1:0]     cnt_q;
   logic [CW-1:0]     win_last;

   assign win_last = is_master ? CW'(MASTER_FRAMES - 1) : CW'(SLAVE_FRAMES - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= PD_OFF;
         cnt_q   <= '0;
      end else begin
         unique case (state_q)
            PD_OFF: begin
               cnt_q   <= '0;
               state_q <= is_master ? PD_INIT : PD_ARM;
            end
            PD_ARM: begin
               if (frame_edge) state_q <= PD_INIT;
            end
            PD_INIT: begin
               if (frame_edge) begin
                  if (cnt_q == win_last) begin
                     cnt_q   <= '0;
                     state_q <= PD_RUN;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
            end
            default: state_q <= PD_RUN;
         endcase
      end
   end

   assign state_o = state_q;

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q < CW'(LONGEST)); // R5
   AST_ARM_SLAVE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PD_ARM) |-> !is_master); // R7
   AST_RUN_FROM_INIT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(state_q == PD_RUN) |-> ($past(state_q) == PD_INIT)); // R6
endmodule

// File: rtl/pdseq_gate.sv
module pdseq_gate #(
   parameter int W = 24
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run,
   input  logic [W-1:0] in_l,
   input  logic [W-1:0] in_r,
   output logic [W-1:0] out_l,
   output logic [W-1:0] out_r,
   output logic         valid_o
);
   localparam int NCH = 2;

   if (W < 1) begin : g_bad_w
      $error("W must be at least 1");
   end

   logic [W-1:0] din    [NCH];
   logic [W-1:0] dout_q [NCH];
   logic         valid_q;

   assign din[0] = in_l;
   assign din[1] = in_r;

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) dout_q[c] <= '0;
         else        dout_q[c] <= run ? din[c] : '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) valid_q <= 1'b0;
      else        valid_q <= run;
   end

   assign out_l   = dout_q[0];
   assign out_r   = dout_q[1];
   assign valid_o = valid_q;

   AST_OUT_ZERO_WHEN_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_q |-> (dout_q[0] == '0 && dout_q[1] == '0)); // R4
   AST_VALID_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      valid_q |=> valid_q); // R8
endmodule

// File: rtl/pd_init_seq.sv
module pd_init_seq
   import pdseq_pkg::*;
#(
   parameter int W             = 24,
   parameter int MASTER_FRAMES = 4129,
   parameter int SLAVE_FRAMES  = 4132
) (
   input  logic         clk,
   input  logic         pdn_n,
   input  logic         master_mode,
   input  logic         i2s_fmt,
   input  logic         lrck,
   input  logic [W-1:0] smp_l_i,
   input  logic [W-1:0] smp_r_i,
   output logic [W-1:0] smp_l_o,
   output logic [W-1:0] smp_r_o,
   output logic         smp_valid_o,
   output logic         filt_rst_o
);
   logic      pdn_q;
   logic      frame_edge;
   pd_state_e state;

   // set at once by power-down, cleared on the first edge after release
   always_ff @(posedge clk or negedge pdn_n) begin
      if (!pdn_n) pdn_q <= 1'b0;
      else        pdn_q <= 1'b1;
   end
   assign filt_rst_o = ~pdn_q;

   pdseq_frame_edge u_edge (
      .clk      (clk),
      .rst_n    (pdn_n),
      .lrck     (lrck),
      .fall_sel (i2s_fmt),
      .edge_o   (frame_edge)
   );

   pdseq_ctrl #(
      .MASTER_FRAMES (MASTER_FRAMES),
      .SLAVE_FRAMES  (SLAVE_FRAMES)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (pdn_n),
      .is_master  (master_mode),
      .frame_edge (frame_edge),
      .state_o    (state)
   );

   pdseq_gate #(.W(W)) u_gate (
      .clk     (clk),
      .rst_n   (pdn_n),
      .run     (state == PD_RUN),
      .in_l    (smp_l_i),
      .in_r    (smp_r_i),
      .out_l   (smp_l_o),
      .out_r   (smp_r_o),
      .valid_o (smp_valid_o)
   );

   AST_FRST_SINGLE: assert property (@(posedge clk) disable iff (!pdn_n)
      filt_rst_o |=> !filt_rst_o); // R2
endmodule

// File: tb/pd_init_seq_tb_top.sv
`timescale 1ns/1ps
module pd_init_seq_tb_top;
   localparam int W      = 24;
   localparam int MFR    = 4129;
   localparam int SFR    = 4132;
   localparam int HALF   = 3;
   localparam int WDOG   = 180000;

   logic         clk = 1'b0;
   logic         pdn_n = 1'b0;
   logic         master_mode = 1'b1;
   logic         i2s_fmt = 1'b0;
   logic         lrck = 1'b0;
   logic [W-1:0] smp_l_i = '0;
   logic [W-1:0] smp_r_i = '0;
   logic [W-1:0] smp_l_o;
   logic [W-1:0] smp_r_o;
   logic         smp_valid_o;
   logic         filt_rst_o;

   int checks = 0;
   int errors = 0;
   logic gen_on = 1'b1;
   int   ph = 0;
   logic done = 1'b0;

   always #5 clk = ~clk;

   pd_init_seq #(.W(W), .MASTER_FRAMES(MFR), .SLAVE_FRAMES(SFR)) dut_i (
      .clk(clk), .pdn_n(pdn_n), .master_mode(master_mode), .i2s_fmt(i2s_fmt),
      .lrck(lrck), .smp_l_i(smp_l_i), .smp_r_i(smp_r_i), .smp_l_o(smp_l_o),
      .smp_r_o(smp_r_o), .smp_valid_o(smp_valid_o), .filt_rst_o(filt_rst_o)
   );

   // frame clock generator, changes away from the rising edge
   always @(negedge clk) begin
      if (gen_on) begin
         if (ph == HALF - 1) begin
            lrck <= ~lrck;
            ph   <= 0;
         end else begin
            ph <= ph + 1;
         end
      end
   end

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // wait for n frame edges of the selected polarity; returns at negedge+1
   task automatic wait_fedges(input int n);
      logic prev;
      int   seen = 0;
      prev = lrck;
      while (seen < n) begin
         @(negedge clk); #1;
         if (lrck !== prev && lrck === ~i2s_fmt) seen++;
         prev = lrck;
      end
   endtask

   task automatic wait_toggle();
      logic prev;
      prev = lrck;
      while (lrck === prev) begin
         @(negedge clk); #1;
      end
   endtask

   task automatic release_pd();
      pdn_n = 1'b1;
      chk("R2 filt_rst before first edge", filt_rst_o, 1);
      @(posedge clk); #1;
      chk("R2 filt_rst after first edge", filt_rst_o, 0);
   endtask

   task automatic t_powerdown();
      pdn_n = 1'b0;
      smp_l_i = 24'h123456; smp_r_i = 24'hABCDEF;
      repeat (20) @(negedge clk);
      #1;
      chk("R1 filt_rst in power-down", filt_rst_o, 1);
      chk("R3 valid in power-down", smp_valid_o, 0);
      chk("R3 left zero in power-down", smp_l_o, 0);
      chk("R3 right zero in power-down", smp_r_o, 0);
   endtask

   task automatic run_window(input string req, input int frames, input logic slave);
      wait_fedges(10);
      smp_l_i = 24'h7FFFFF; smp_r_i = 24'h800001;
      repeat (2) @(negedge clk); #1;
      chk("R4 valid during init", smp_valid_o, 0);
      chk("R4 left zero during init", smp_l_o, 0);
      chk("R4 right zero during init", smp_r_o, 0);
      wait_fedges(frames + (slave ? 1 : 0) - 11);
      repeat (2) @(negedge clk); #1;
      chk({req, " valid low one frame early"}, smp_valid_o, 0);
      wait_fedges(1);
      repeat (2) @(negedge clk); #1;
      chk({req, " valid high at window end"}, smp_valid_o, 1);
      chk("R8 left passes", smp_l_o, 24'h7FFFFF);
      chk("R8 right passes", smp_r_o, 24'h800001);
      smp_l_i = 24'h000042; smp_r_i = 24'hFFFF00;
      @(negedge clk); #1;
      chk("R8 left follows one cycle later", smp_l_o, 24'h000042);
      chk("R8 right follows one cycle later", smp_r_o, 24'hFFFF00);
      chk("R8 valid stays high", smp_valid_o, 1);
   endtask

   task automatic t_master(input logic fmt);
      pdn_n = 1'b0; master_mode = 1'b1; i2s_fmt = fmt; gen_on = 1'b1;
      repeat (5) @(negedge clk);
      wait_toggle();
      @(negedge clk); #1;
      release_pd();
      run_window(fmt ? "R5 R7 master i2s" : "R5 master", MFR, 1'b0);
   endtask

   task automatic t_slave(input logic fmt, input logic idle_first);
      pdn_n = 1'b0; master_mode = 1'b0; i2s_fmt = fmt;
      repeat (5) @(negedge clk);
      if (idle_first) begin
         gen_on = 1'b0;
         @(negedge clk); #1;
         release_pd();
         repeat (200) @(negedge clk);
         #1;
         chk("R7 slave idle without frame clock", smp_valid_o, 0);
         gen_on = 1'b1;
      end else begin
         gen_on = 1'b1;
         wait_toggle();
         @(negedge clk); #1;
         release_pd();
      end
      run_window(fmt ? "R6 R7 slave i2s" : "R6 slave", SFR, 1'b1);
   endtask

   task automatic t_abort_run();
      @(negedge clk); #1;
      pdn_n = 1'b0;
      #1;
      chk("R9 valid drops at once in run", smp_valid_o, 0);
      chk("R9 left zero at once", smp_l_o, 0);
      chk("R1 filt_rst rises at once", filt_rst_o, 1);
   endtask

   task automatic t_abort_init();
      pdn_n = 1'b0; master_mode = 1'b1; i2s_fmt = 1'b0;
      repeat (5) @(negedge clk);
      wait_toggle();
      @(negedge clk); #1;
      release_pd();
      wait_fedges(1000);
      pdn_n = 1'b0;
      #1;
      chk("R9 filt_rst on abort in init", filt_rst_o, 1);
      chk("R9 valid low on abort in init", smp_valid_o, 0);
   endtask

   initial begin
      #1;
      chk("R1 filt_rst at start", filt_rst_o, 1);
      chk("R3 valid at start", smp_valid_o, 0);
      t_powerdown();
      t_master(1'b0);
      t_abort_run();
      t_slave(1'b0, 1'b1);
      t_abort_init();
      t_master(1'b1);   // full window after abort: R9
      t_slave(1'b1, 1'b0);
      done = 1'b1;
   end

   initial begin
      int cyc = 0;
      while (!done && cyc < WDOG) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule